// File: doc/BRIEF.md
# Response Age Stamper and Lateness Classifier

This block sits on the flit path of a router port or at the output of a memory controller. Each memory message carries a running "age" in its header flit: the delay it has built up so far. When a header flit goes through, the block adds the cycles the message spent at this node. The node supplies that count next to the flit, and at a memory controller it includes queuing and service time. The count is first scaled by a per-node clock ratio, so that nodes running at different frequencies add delay in common units. No global time base is needed. The age sits in spare header bits, so no flit is added.

Response headers are then classified. The updated age is compared against a lateness threshold chosen by the source core field of the header. A response older than its core's threshold gets its high-priority bit set before it moves on. Request headers take the age update but keep their priority bit. Body flits pass untouched. Software or the cores refresh the per-core thresholds and the clock ratio through a small write-only configuration port.

Top module: `resp_age_classifier`

## Requirements
- R1: After reset, out_valid is 0, every threshold is all ones (4095), and the clock ratio is 4, which is a scale factor of 1.0.
- R2: For a header flit (in_head=1), the 12-bit age field at bits [AGE_LSB+:12] (default [107:96]) leaves with the value age + ((in_resid * ratio) >> 2). The ratio is an unsigned 4-bit value with two fraction bits.
- R3: The age addition saturates at 4095 and never wraps. This includes a product that alone exceeds 4095.
- R4: A header with type bit TYPE_POS (bit 127) = 1 is a response. When its updated age is strictly greater than the threshold of its source field [SRC_LSB+:SRC_W] (default [112:108]), the block sets the priority bit PRIO_POS (bit 126) and raises out_late. An age equal to the threshold is not late.
- R5: A request header (type bit 0), or a response that is not late, leaves with its priority bit unchanged, and out_late stays 0.
- R6: A body flit (in_head=0) leaves bit-for-bit unchanged, with out_late 0 and out_head 0.
- R7: A flit accepted on a clock edge (in_valid and in_ready high) is presented on the output port at that same edge, one stage later. in_ready equals !out_valid || out_ready. While out_ready is low, out_flit and out_late hold steady.
- R8: A configuration write with cfg_sel=0 sets the threshold of core cfg_idx to cfg_data. The new value applies to headers accepted after the write edge, and no other core's threshold changes.
- R9: A configuration write with cfg_sel=1 sets the clock ratio to cfg_data[3:0]. The new ratio applies to headers accepted after the write edge.
- R10: Every header bit outside the age field and the priority bit passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Block can take a flit |
| in_flit | input | FLIT_W (128) | Incoming flit |
| in_head | input | 1 | Flit is a header |
| in_resid | input | RES_W (16) | Local residency cycles for this message |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream takes the flit |
| out_flit | output | FLIT_W (128) | Stamped flit |
| out_head | output | 1 | Output flit is a header |
| out_late | output | 1 | Response was classified late |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: threshold, 1: clock ratio |
| cfg_idx | input | SRC_W (5) | Core index for a threshold write |
| cfg_data | input | AGE_W (12) | Write data |

## Verification
The bench builds the block with SRC_W=2, which gives four cores and a four-entry threshold table. All other parameters keep their defaults. The small table lets the bench give each core a distinct threshold and rotate through the cores in a single sweep. The sweep covers all 16 clock ratios, a spread of residency counts up to the point where the product saturates on its own, and ages from 0 to 4095, for both responses and requests. Separate targeted cases cover equality with the threshold, writes that leave the other table entries alone, body flits, and back-pressure.

// File: rtl/age_cls_pkg.sv
package age_cls_pkg;
   typedef enum logic {
      CFG_THRESH = 1'b0,
      CFG_RATIO  = 1'b1
   } cfg_sel_e;

   typedef struct packed {
      logic head;
      logic late;
   } flit_tag_t;
endpackage

// File: rtl/age_scaler.sv
module age_scaler #(
   parameter int AGE_W   = 12,
   parameter int RES_W   = 16,
   parameter int RATIO_W = 4,
   parameter int FRAC_SH = 2
) (
   input  logic [AGE_W-1:0]   age_in,
   input  logic [RES_W-1:0]   resid,
   input  logic [RATIO_W-1:0] ratio,
   output logic [AGE_W-1:0]   age_out,
   output logic               sat
);
   localparam int PW  = RES_W + RATIO_W;
   localparam int SW  = PW + 1;
   localparam int PAD = SW - AGE_W;

   if (PW < AGE_W) begin : g_bad_width
      $error("age_scaler: RES_W+RATIO_W must be at least AGE_W");
   end
   if (FRAC_SH >= PW) begin : g_bad_shift
      $error("age_scaler: FRAC_SH too large");
   end

   logic [PW-1:0] prod;
   logic [PW-1:0] scaled;
   logic [SW-1:0] sum;

   assign prod = {{RATIO_W{1'b0}}, resid} * {{RES_W{1'b0}}, ratio};

   if (FRAC_SH == 0) begin : g_noshift
      assign scaled = prod;
   end else begin : g_shift
      assign scaled = prod >> FRAC_SH;
   end

   assign sum     = {1'b0, scaled} + {{PAD{1'b0}}, age_in};
   assign sat     = sum > {{PAD{1'b0}}, {AGE_W{1'b1}}};
   assign age_out = sat ? {AGE_W{1'b1}} : sum[AGE_W-1:0];

   // R3: the result never falls below the incoming age (no wrap)
   always_comb begin
      p_no_wrap_r3: assert (age_out >= age_in || $isunknown(age_in) || $isunknown(resid) || $isunknown(ratio));
   end
endmodule

// File: rtl/thr_table.sv
module thr_table
   import age_cls_pkg::*;
#(
   parameter int SRC_W     = 5,
   parameter int AGE_W     = 12,
   parameter int RATIO_W   = 4,
   parameter int RATIO_RST = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  cfg_sel_e           cfg_sel,
   input  logic [SRC_W-1:0]   cfg_idx,
   input  logic [AGE_W-1:0]   cfg_data,
   input  logic [SRC_W-1:0]   rd_idx,
   output logic [AGE_W-1:0]   rd_thr,
   output logic [RATIO_W-1:0] ratio
);
   localparam int NSRC = 1 << SRC_W;

   if (RATIO_W > AGE_W) begin : g_bad_ratio
      $error("thr_table: RATIO_W must not exceed AGE_W");
   end
   if (RATIO_RST >= (1 << RATIO_W)) begin : g_bad_rst
      $error("thr_table: RATIO_RST does not fit");
   end

   logic [AGE_W-1:0] thr_q [NSRC];

   for (genvar i = 0; i < NSRC; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            thr_q[i] <= {AGE_W{1'b1}};
         else if (cfg_we && cfg_sel == CFG_THRESH && cfg_idx == SRC_W'(i))
            thr_q[i] <= cfg_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ratio <= RATIO_W'(RATIO_RST);
      else if (cfg_we && cfg_sel == CFG_RATIO)
         ratio <= cfg_data[RATIO_W-1:0];
   end

   assign rd_thr = thr_q[rd_idx];

   // R9: ratio changes only on a ratio write
   p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == CFG_RATIO) |=> $stable(ratio));
endmodule

// File: rtl/age_stage.sv
module age_stage
   import age_cls_pkg::*;
#(
   parameter int FLIT_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLIT_W-1:0] in_flit,
   input  flit_tag_t         in_tag,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [FLIT_W-1:0] out_flit,
   output flit_tag_t         out_tag
);
   logic v_q;

   assign in_ready  = !v_q || out_ready;
   assign out_valid = v_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         v_q <= 1'b0;
      else if (in_ready)
         v_q <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid && in_ready) begin
         out_flit <= in_flit;
         out_tag  <= in_tag;
      end
   end

   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_flit) && $stable(out_tag));
   p_accept_shows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/resp_age_classifier.sv
module resp_age_classifier
   import age_cls_pkg::*;
#(
   parameter int FLIT_W    = 128,
   parameter int AGE_W     = 12,
   parameter int AGE_LSB   = 96,
   parameter int SRC_W     = 5,
   parameter int SRC_LSB   = 108,
   parameter int TYPE_POS  = 127,
   parameter int PRIO_POS  = 126,
   parameter int RES_W     = 16,
   parameter int RATIO_W   = 4,
   parameter int FRAC_SH   = 2,
   parameter int RATIO_RST = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLIT_W-1:0] in_flit,
   input  logic              in_head,
   input  logic [RES_W-1:0]  in_resid,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [FLIT_W-1:0] out_flit,
   output logic              out_head,
   output logic              out_late,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [SRC_W-1:0]  cfg_idx,
   input  logic [AGE_W-1:0]  cfg_data
);
   localparam int AGE_MSB = AGE_LSB + AGE_W - 1;
   localparam int SRC_MSB = SRC_LSB + SRC_W - 1;

   if (AGE_MSB >= FLIT_W || SRC_MSB >= FLIT_W || TYPE_POS >= FLIT_W || PRIO_POS >= FLIT_W) begin : g_bad_pos
      $error("resp_age_classifier: header field outside flit");
   end
   if ((PRIO_POS >= AGE_LSB && PRIO_POS <= AGE_MSB) || (TYPE_POS >= AGE_LSB && TYPE_POS <= AGE_MSB)
       || PRIO_POS == TYPE_POS) begin : g_bad_overlap
      $error("resp_age_classifier: header fields overlap");
   end
   if (!(SRC_LSB > AGE_MSB || SRC_MSB < AGE_LSB)) begin : g_bad_src
      $error("resp_age_classifier: source field overlaps age");
   end

   logic [AGE_W-1:0]   age_in, age_new, thr;
   logic [SRC_W-1:0]   src;
   logic [RATIO_W-1:0] ratio;
   logic               is_resp, late, sat;
   logic [FLIT_W-1:0]  nxt_flit;
   flit_tag_t          in_tag, out_tag;

   assign age_in  = in_flit[AGE_LSB +: AGE_W];
   assign src     = in_flit[SRC_LSB +: SRC_W];
   assign is_resp = in_flit[TYPE_POS];

   thr_table #(
      .SRC_W(SRC_W), .AGE_W(AGE_W), .RATIO_W(RATIO_W), .RATIO_RST(RATIO_RST)
   ) u_tab (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel_e'(cfg_sel)),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .rd_idx(src), .rd_thr(thr), .ratio(ratio)
   );

   age_scaler #(
      .AGE_W(AGE_W), .RES_W(RES_W), .RATIO_W(RATIO_W), .FRAC_SH(FRAC_SH)
   ) u_scale (
      .age_in(age_in), .resid(in_resid), .ratio(ratio),
      .age_out(age_new), .sat(sat)
   );

   always_comb begin
      late     = in_head && is_resp && (age_new > thr);
      nxt_flit = in_flit;
      if (in_head)
         nxt_flit[AGE_LSB +: AGE_W] = age_new;
      if (late)
         nxt_flit[PRIO_POS] = 1'b1;
   end

   assign in_tag = '{head: in_head, late: late};

   age_stage #(.FLIT_W(FLIT_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_flit(nxt_flit), .in_tag(in_tag),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_flit(out_flit), .out_tag(out_tag)
   );

   assign out_head = out_tag.head;
   assign out_late = out_tag.late;

   logic unused_sat;
   assign unused_sat = sat;

   // R4/R5: lateness only on response headers, and always with priority set
   p_late_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_late |-> out_head && out_flit[TYPE_POS]);
   p_late_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_late |-> out_flit[PRIO_POS]);
   // R2: a freshly accepted header leaves no younger than it came in
   p_age_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_head |=>
         out_flit[AGE_LSB +: AGE_W] >= $past(in_flit[AGE_LSB +: AGE_W]));
   // R6: body flits leave unchanged
   p_body_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_head |=> out_flit == $past(in_flit) && !out_late);
endmodule

// File: tb/resp_age_classifier_tb.sv
module resp_age_classifier_tb;
   localparam int SRC_W = 2;
   localparam logic [127:0] FILL = 128'h0DEF_1234_5678_9ABC_F00D_CAFE_BEEF_5A5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_head = 1'b0, out_ready = 1'b1;
   logic [127:0] in_flit = '0;
   logic [15:0] in_resid = '0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [SRC_W-1:0] cfg_idx = '0;
   logic [11:0] cfg_data = '0;
   logic in_ready, out_valid, out_head, out_late;
   logic [127:0] out_flit;

   int total = 0, bad = 0;
   int cycles = 0;
   int thr_m [4];
   int ratio_m = 4;

   always #2 clk = ~clk;

   resp_age_classifier #(.SRC_W(SRC_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
      .in_head(in_head), .in_resid(in_resid),
      .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
      .out_head(out_head), .out_late(out_late),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data)
   );

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(bit resp, bit prio, int src, int age);
      logic [127:0] f = FILL;
      f[127] = resp;
      f[126] = prio;
      f[108 +: SRC_W] = SRC_W'(src);
      f[96 +: 12] = 12'(age);
      return f;
   endfunction

   task automatic cfg(bit sel, int idx, int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = SRC_W'(idx); cfg_data = 12'(data);
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) ratio_m = data & 15; else thr_m[idx] = data & 4095;
   endtask

   // send one flit; at the following falling edge the result is on the output
   task automatic send(logic [127:0] f, bit head, int resid);
      @(negedge clk);
      in_valid = 1'b1; in_flit = f; in_head = head; in_resid = 16'(resid);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic hdr_case(bit resp, bit prio, int src, int age, int resid);
      int raw, exp_age;
      bit exp_late;
      logic [127:0] exp_f, rest_a, rest_e;
      raw = age + ((resid * ratio_m) >> 2);
      exp_age = raw > 4095 ? 4095 : raw;
      exp_late = resp && (exp_age > thr_m[src]);
      send(mk(resp, prio, src, age), 1'b1, resid);
      exp_f = mk(resp, prio | exp_late, src, exp_age);
      check(raw > 4095 ? "R3 saturated age" : "R2 age update",
            128'(out_flit[96 +: 12]), 128'(exp_age));
      check(resp ? "R4 priority bit" : "R5 request priority kept",
            128'(out_flit[126]), 128'(exp_f[126]));
      check(resp ? "R4 late flag" : "R5 request not late", 128'(out_late), 128'(exp_late));
      rest_a = out_flit; rest_a[96 +: 12] = '0; rest_a[126] = 1'b0;
      rest_e = exp_f;    rest_e[96 +: 12] = '0; rest_e[126] = 1'b0;
      check("R10 other bits", rest_a, rest_e);
      check("R7 valid after accept", 128'({out_valid, out_head}), 128'(2'b11));
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : main
      for (int i = 0; i < 4; i++) thr_m[i] = 4095;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid after reset", 128'(out_valid), 128'(0));
      check("R1 in_ready after reset", 128'(in_ready), 128'(1));
      hdr_case(1, 0, 0, 4095, 0);   // reset threshold 4095: not late
      hdr_case(1, 0, 3, 10, 10);    // reset ratio 4: adds 10
      check("R1 ratio one", 128'(out_flit[96 +: 12]), 128'(20));

      // R6 body flit
      send(FILL ^ 128'h1, 1'b0, 999);
      check("R6 body unchanged", out_flit, FILL ^ 128'h1);
      check("R6 body not late/head", 128'({out_late, out_head}), 128'(0));

      // R8 thresholds per core
      for (int i = 0; i < 4; i++) cfg(0, i, 300 + 500 * i);
      cfg(0, 2, 1000);
      hdr_case(1, 0, 2, 1000, 0);   // equal: not late
      hdr_case(1, 0, 2, 1001, 0);   // above: late
      check("R8 threshold written", 128'(out_late), 128'(1));
      hdr_case(1, 0, 1, 801, 0);    // core 1 kept 800
      check("R8 neighbour unchanged", 128'(out_late), 128'(1));
      hdr_case(1, 0, 1, 800, 0);
      check("R8 neighbour boundary", 128'(out_late), 128'(0));
      hdr_case(1, 1, 0, 5, 0);      // prio already set, not late
      hdr_case(0, 0, 3, 4000, 500); // request past threshold

      // R9/R2/R3/R4/R5 sweep over ratios, residencies, ages
      for (int r = 0; r < 16; r++) begin
         cfg(1, 0, r);
         foreach (thr_m[k]) ;
         for (int j = 0; j < 8; j++) begin
            int rl [8] = '{0, 1, 3, 7, 100, 255, 1000, 40000};
            for (int a = 0; a < 5; a++) begin
               int al [5] = '{0, 299, 1799, 4000, 4095};
               hdr_case(1, 0, (j + a) % 4, al[a], rl[j]);
               hdr_case(0, 0, (j + a + 1) % 4, al[a], rl[j]);
            end
         end
      end

      // R7 back-pressure
      cfg(1, 0, 4);
      out_ready = 1'b0;
      send(mk(1, 0, 0, 100), 1'b1, 8);
      @(negedge clk);
      in_valid = 1'b1; in_flit = FILL; in_head = 1'b0;
      check("R7 ready low when full", 128'(in_ready), 128'(0));
      repeat (3) @(negedge clk);
      check("R7 held flit", out_flit, mk(1, 0, 0, 108));
      check("R7 held valid", 128'(out_valid), 128'(1));
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 next flit after drain", out_flit, FILL);
      @(negedge clk);
      check("R7 drained", 128'(out_valid), 128'(0));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule